// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block joins two eight-input priority interrupt units into one sixteen-line controller that drives a single interrupt line toward a processor. Lines 0 to 7 go to the primary unit, lines 8 to 15 go to the secondary unit. The secondary unit reports its own pending state into input 2 of the primary unit, so any secondary request is seen as a primary pin-2 request. Bit 3 of a global line number selects the unit. Bits 2:0 select the pin within that unit.

Each line has a trigger-mode bit. A clear bit means edge mode and a set bit means level mode. Each line also has a small saturating assertion counter, and the line counts as asserted when its counter is nonzero. A pulse input asserts and deasserts a line within one update. When the processor acknowledges the interrupt, the block reports an 8-bit vector and marks the chosen pins in service. Each unit has a nonspecific end-of-interrupt strobe that retires its highest-priority in-service pin.

The processor-interrupt state machine has two states. In `ST_IDLE` the interrupt is low. It moves to `ST_RAISED` on the clock after the primary unit has an eligible request. In `ST_RAISED` the interrupt is high. It moves back to `ST_IDLE` on the clock where the acknowledge strobe is high.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, `cpu_int` is 0 and `elc_rdata` is 0, which puts every line in edge mode.
- R2: The vector is the unit base plus the pin number. The primary base is 0x20 and the secondary base is 0x28. For example, line 5 reports 0x25 and line 11 reports 0x2B.
- R3: A secondary request raises primary pin 2. `cpu_int` then rises, and the vector comes from the secondary unit's winning pin.
- R4: `cpu_int` rises on the clock after the primary unit gains an eligible request. It falls on the clock that samples `int_ack` high.
- R5: In edge mode, a request is set only when the line goes from deasserted to asserted. A line held high after its acknowledge and end-of-interrupt raises no new request.
- R6: In level mode, the request follows the line. A line still high after acknowledge and end-of-interrupt requests again. A line that has been dropped does not.
- R7: A pulse on an edge-mode line that is deasserted sets a request. A pulse on a level-mode line leaves no request.
- R8: Line changes on a unit whose bit in `unit_ready` is 0 are ignored. They are also not replayed when the unit becomes ready.
- R9: An acknowledge of a secondary vector marks both the secondary pin and primary pin 2 in service. Primary pins 3 to 7 therefore stay blocked until the primary unit receives an end-of-interrupt.
- R10: A lower pin number has higher priority. A pin is eligible only when no in-service pin of the same or higher priority is set. This lets a higher-priority line interrupt an in-service lower-priority one.
- R11: Writes to the trigger-mode register are masked. Primary lines 0, 1 and 2 and secondary lines 8 and 13 stay in edge mode. `elc_rdata` is {secondary[7:0], primary[7:0]}.
- R12: End-of-interrupt clears only the highest-priority in-service bit of its unit.
- R13: Line 2 has no effect, because primary input 2 carries only the cascade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| unit_ready | input | 2 | Bit 0 primary, bit 1 secondary: unit accepts line changes |
| line_req | input | 16 | Request line levels |
| line_pulse | input | 16 | One-update assert/deassert pulses |
| elc_we | input | 1 | Trigger-mode register write strobe |
| elc_sel | input | 1 | 0 selects the primary register, 1 selects the secondary register |
| elc_wdata | input | 8 | Trigger-mode write data |
| elc_rdata | output | 16 | Trigger-mode bits for lines 15..0 |
| int_ack | input | 1 | Processor acknowledge |
| eoi | input | 2 | End-of-interrupt strobe for each unit |
| cpu_int | output | 1 | Interrupt to processor |
| vector | output | 8 | Vector for the current winner |

## Verification
The main path is tried with:
- a single primary line, which shows the unit base and pin arithmetic;
- a single secondary line, which shows that the cascade substitutes the secondary base;
- two primary lines raised together, which shows that priority picks the lower pin;
- a high-priority line arriving during service, which separates nested preemption from simple queuing.

Held lines under both trigger modes after end-of-interrupt separate edge capture from level following. Pulses in each mode separate transient capture from net level. A blocked pin-5 request after a secondary acknowledge shows that the cascade pin was also retired into service.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RAISED = 1'b1
    } int_state_e;
endpackage

// File: rtl/pic_line_cell.sv
module pic_line_cell #(
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic level_mode,
    input  logic req_in,
    input  logic pulse_in,
    input  logic accept,
    output logic irr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             req_q;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             rise, fall, was_on, now_on, edge_hit;

    always_comb begin
        rise   = req_in & ~req_q;
        fall   = ~req_in & req_q;
        cnt_nx = cnt;
        if (rise && cnt != CNT_MAX)
            cnt_nx = cnt + 1'b1;
        else if (fall && cnt != '0)
            cnt_nx = cnt - 1'b1;
        was_on   = (cnt != '0);
        now_on   = (cnt_nx != '0);
        edge_hit = (!was_on && now_on) || (pulse_in && !now_on);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            cnt   <= '0;
            irr   <= 1'b0;
        end else begin
            req_q <= req_in;
            if (en) begin
                cnt <= cnt_nx;
                if (accept)
                    irr <= level_mode & now_on;
                else if (level_mode)
                    irr <= now_on;
                else if (edge_hit)
                    irr <= 1'b1;
            end
        end
    end

    assert_ignore_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irr) |-> $past(en));
endmodule

// File: rtl/pic_unit.sv
module pic_unit #(
    parameter int              NPIN      = 8,
    parameter int              CNT_W     = 2,
    parameter logic [NPIN-1:0] CASC_MASK = '0,
    localparam int             PW        = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [NPIN-1:0] level_mode,
    input  logic [NPIN-1:0] req,
    input  logic [NPIN-1:0] pulse,
    input  logic            casc_in,
    input  logic            accept,
    input  logic [PW-1:0]   accept_pin,
    input  logic            eoi,
    output logic            pend,
    output logic [PW-1:0]   win_pin
);
    logic [NPIN-1:0] irr, eff, isr, acc_mask, eoi_mask;
    logic            blocked, found;

    for (genvar p = 0; p < NPIN; p++) begin : g_line
        assign acc_mask[p] = accept && (accept_pin == PW'(p));
        pic_line_cell #(.CNT_W(CNT_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .en(en),
            .level_mode(level_mode[p]), .req_in(req[p]), .pulse_in(pulse[p]),
            .accept(acc_mask[p]), .irr(irr[p])
        );
    end

    assign eff = (irr & ~CASC_MASK) | (CASC_MASK & {NPIN{casc_in}});

    always_comb begin
        pend    = 1'b0;
        win_pin = '0;
        blocked = 1'b0;
        for (int p = 0; p < NPIN; p++) begin
            blocked = blocked | isr[p];
            if (!pend && eff[p] && !blocked) begin
                pend    = 1'b1;
                win_pin = PW'(p);
            end
        end
    end

    always_comb begin
        eoi_mask = '0;
        found    = 1'b0;
        for (int p = 0; p < NPIN; p++) begin
            if (!found && isr[p]) begin
                eoi_mask[p] = eoi;
                found       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            isr <= '0;
        else
            isr <= (isr & ~eoi_mask) | acc_mask;
    end

    assert_isr_by_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(isr & ~$past(isr))) |-> $past(accept));

    assert_eoi_one_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eoi) && !$past(accept) && (|$past(isr)))
            |-> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
    parameter logic [7:0] MASTER_BASE = 8'h20,
    parameter logic [7:0] SLAVE_BASE  = 8'h28,
    parameter logic [7:0] M_ELC_WMASK = 8'hF8,
    parameter logic [7:0] S_ELC_WMASK = 8'hDE,
    parameter int         CNT_W       = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  unit_ready,
    input  logic [15:0] line_req,
    input  logic [15:0] line_pulse,
    input  logic        elc_we,
    input  logic        elc_sel,
    input  logic [7:0]  elc_wdata,
    output logic [15:0] elc_rdata,
    input  logic        int_ack,
    input  logic [1:0]  eoi,
    output logic        cpu_int,
    output logic [7:0]  vector
);
    import pic_cascade_pkg::*;

    localparam int         NPIN     = 8;
    localparam int         PW       = $clog2(NPIN);
    localparam int         CASC_PIN = 2;
    localparam logic [7:0] CASC_BIT = 8'(1) << CASC_PIN;

    int_state_e    state_q, state_nx;
    logic [7:0]    elc_m, elc_s;
    logic          m_pend, s_pend, ack_go, to_slave;
    logic [PW-1:0] m_win, s_win, m_acc_pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elc_m <= '0;
            elc_s <= '0;
        end else if (elc_we) begin
            if (elc_sel)
                elc_s <= (elc_s & ~S_ELC_WMASK) | (elc_wdata & S_ELC_WMASK);
            else
                elc_m <= (elc_m & ~M_ELC_WMASK) | (elc_wdata & M_ELC_WMASK);
        end
    end
    assign elc_rdata = {elc_s, elc_m};

    always_comb begin
        if (m_win == PW'(CASC_PIN))
            vector = {SLAVE_BASE[7:3], s_win};
        else
            vector = {MASTER_BASE[7:3], m_win};
    end

    assign ack_go    = int_ack && (state_q == ST_RAISED) && m_pend;
    assign to_slave  = (vector[7:3] == SLAVE_BASE[7:3]);
    assign m_acc_pin = to_slave ? PW'(CASC_PIN) : m_win;

    pic_unit #(.NPIN(NPIN), .CNT_W(CNT_W), .CASC_MASK('0)) u_slave (
        .clk(clk), .rst_n(rst_n), .en(unit_ready[1]),
        .level_mode(elc_s), .req(line_req[15:8]), .pulse(line_pulse[15:8]),
        .casc_in(1'b0), .accept(ack_go && to_slave), .accept_pin(s_win),
        .eoi(eoi[1]), .pend(s_pend), .win_pin(s_win)
    );

    pic_unit #(.NPIN(NPIN), .CNT_W(CNT_W), .CASC_MASK(CASC_BIT)) u_master (
        .clk(clk), .rst_n(rst_n), .en(unit_ready[0]),
        .level_mode(elc_m), .req(line_req[7:0]), .pulse(line_pulse[7:0]),
        .casc_in(s_pend), .accept(ack_go), .accept_pin(m_acc_pin),
        .eoi(eoi[0]), .pend(m_pend), .win_pin(m_win)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (m_pend)  state_nx = ST_RAISED;
            ST_RAISED: if (int_ack) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign cpu_int = (state_q == ST_RAISED);

    assert_raise_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_int) |-> $past(m_pend));

    assert_vec_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |-> (vector[7:3] == MASTER_BASE[7:3] || vector[7:3] == SLAVE_BASE[7:3]));
endmodule

// File: tb/sim_cascade_irq_ctrl.sv
module sim_cascade_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  unit_ready = 2'b11;
    logic [15:0] line_req = '0, line_pulse = '0;
    logic        elc_we = 1'b0, elc_sel = 1'b0;
    logic [7:0]  elc_wdata = '0;
    logic [15:0] elc_rdata;
    logic        int_ack = 1'b0;
    logic [1:0]  eoi = '0;
    logic        cpu_int;
    logic [7:0]  vector;
    int          errors = 0, checks = 0;

    always #4 clk = ~clk;

    cascade_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .unit_ready(unit_ready), .line_req(line_req),
        .line_pulse(line_pulse), .elc_we(elc_we), .elc_sel(elc_sel),
        .elc_wdata(elc_wdata), .elc_rdata(elc_rdata), .int_ack(int_ack),
        .eoi(eoi), .cpu_int(cpu_int), .vector(vector)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic see_int(input string tag, input bit exp_int, input int exp_vec);
        chk(cpu_int == exp_int, tag, int'(cpu_int), int'(exp_int));
        if (exp_int) chk(vector == exp_vec[7:0], tag, int'(vector), exp_vec);
    endtask

    task automatic ack();
        int_ack = 1'b1; tick(1); int_ack = 1'b0;
    endtask

    task automatic end_int(input logic [1:0] u);
        eoi = u; tick(1); eoi = '0;
    endtask

    task automatic t_reset();
        tick(2); rst_n = 1'b1; tick(1);
        chk(cpu_int == 1'b0, "R1 int", int'(cpu_int), 0);
        chk(elc_rdata == 16'h0, "R1 elc", int'(elc_rdata), 0);
    endtask

    task automatic t_edge();
        line_req[5] = 1'b1; tick(1);
        chk(cpu_int == 1'b0, "R4 not yet", int'(cpu_int), 0);
        tick(1); see_int("R2 R4 line5", 1'b1, 'h25);
        ack();
        chk(cpu_int == 1'b0, "R4 drop on ack", int'(cpu_int), 0);
        tick(3); see_int("R5 held", 1'b0, 0);
        end_int(2'b01); tick(2); see_int("R5 held after eoi", 1'b0, 0);
        line_req[5] = 1'b0; tick(1);
    endtask

    task automatic t_cascade();
        line_req[11] = 1'b1; tick(2); see_int("R3 R2 line11", 1'b1, 'h2B);
        ack(); line_req[11] = 1'b0;
        line_req[5] = 1'b1; tick(3); see_int("R9 pin2 blocks 5", 1'b0, 0);
        end_int(2'b11); tick(1); see_int("R9 after eoi", 1'b1, 'h25);
        ack(); end_int(2'b01); line_req[5] = 1'b0; tick(2);
    endtask

    task automatic t_priority();
        line_req[6] = 1'b1; line_req[4] = 1'b1; tick(2);
        see_int("R10 lower pin wins", 1'b1, 'h24);
        ack(); tick(2); see_int("R10 6 blocked", 1'b0, 0);
        line_req[1] = 1'b1; tick(2); see_int("R10 nested", 1'b1, 'h21);
        ack(); end_int(2'b01); tick(2);
        see_int("R12 only pin1 retired", 1'b0, 0);
        end_int(2'b01); tick(1); see_int("R12 pin4 retired", 1'b1, 'h26);
        ack(); end_int(2'b01);
        line_req[6] = 1'b0; line_req[4] = 1'b0; line_req[1] = 1'b0; tick(2);
    endtask

    task automatic t_elc();
        elc_we = 1'b1; elc_sel = 1'b0; elc_wdata = 8'hFF; tick(1);
        elc_sel = 1'b1; tick(1); elc_we = 1'b0;
        chk(elc_rdata == 16'hDEF8, "R11 masked", int'(elc_rdata), 'hDEF8);
    endtask

    task automatic t_level();
        line_req[3] = 1'b1; tick(2); see_int("R6 level", 1'b1, 'h23);
        ack(); end_int(2'b01); tick(1); see_int("R6 re-request", 1'b1, 'h23);
        ack(); line_req[3] = 1'b0; end_int(2'b01); tick(3);
        see_int("R6 withdrawn", 1'b0, 0);
    endtask

    task automatic t_pulse();
        line_pulse[6] = 1'b1; tick(1); line_pulse[6] = 1'b0; tick(2);
        see_int("R7 level pulse", 1'b0, 0);
        line_pulse[1] = 1'b1; tick(1); line_pulse[1] = 1'b0; tick(1);
        see_int("R7 edge pulse", 1'b1, 'h21);
        ack(); end_int(2'b01); tick(2);
    endtask

    task automatic t_ready();
        unit_ready = 2'b10; line_req[1] = 1'b1; tick(3);
        see_int("R8 not ready", 1'b0, 0);
        unit_ready = 2'b11; tick(2); see_int("R8 no replay", 1'b0, 0);
        line_req[1] = 1'b0; tick(1);
    endtask

    task automatic t_casc_line();
        line_req[2] = 1'b1; tick(3); see_int("R13 line2", 1'b0, 0);
        line_req[2] = 1'b0; tick(1);
    endtask

    initial begin
        t_reset();
        t_edge();
        t_cascade();
        t_priority();
        t_elc();
        t_level();
        t_pulse();
        t_ready();
        t_casc_line();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1600000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule